// File: doc/BRIEF.md
# Debug Emulation Mode Controller

This block keeps a single flag that says whether the processor core is in debug emulation mode, and it drives what that mode does to the rest of the core. There are three ways in, and each is looked at only at its own exception boundary. A force bit is honoured when reset exception processing starts with the reset pin negated. An enabled debug interrupt enters the mode when interrupt exception processing begins. The trace bit enters it when trace exception processing begins. Retiring a return-from-exception instruction leaves the mode.

While the flag is set, the interrupt priority level passed on to the core is held at zero. When the remap control bit is also set, the local cache and SRAM enables are forced off. Every memory access is then tagged with a special transfer type and a modifier that depends on the access class. This tagging starts in the entry cycle, so the exception that caused entry has its stack frame and vector fetch tagged too. The 4-bit status output passes the core's own code through, except in an entry or exit cycle, where it carries a dedicated marker.

The core drives the strobes for one cycle each. The outputs that follow from the events are combinational, and the flag changes at the next clock edge.

Top module: `emu_mode_ctrl`

## Requirements
- R1: A low rst_n at a clock edge clears emu_active, and the bench observes 0 in the next cycle.
- R2: When reset_exc_start, rst_pin_negated and force_emu are all high at an edge, emu_active is 1 afterwards. Without all three, the force bit does not change the flag.
- R3: When irq_exc_begin, dbg_irq_req and dbg_enable are all high at an edge, emu_active is 1 afterwards.
- R4: When trace_exc_begin and trace_en are both high at an edge, emu_active is 1 afterwards.
- R5: When rte_retire is high at an edge while emu_active is 1 and no entry trigger is present, emu_active is 0 afterwards. When emu_active is 0, rte_retire has no effect on the flag.
- R6: In a cycle where any entry trigger is present, pst_code is 4'hD.
- R7: In a cycle with an exit event (R5), pst_code is 4'h7. In any cycle with neither entry nor exit, pst_code equals core_status.
- R8: When an entry trigger and rte_retire fall in the same cycle, entry wins: pst_code is 4'hD and emu_active is 1 afterwards.
- R9: While emu_active is 1, irq_level_out is 3'd0 for every irq_level_in, including 7. Otherwise irq_level_out equals irq_level_in.
- R10: When remap_en is 1 and emu_active is 1, local_mem_off and acc_ovr are 1, acc_tt is 2'h2, and acc_tm is 3'h5 for a data access (acc_is_instr=0) or 3'h6 for an instruction access. Otherwise all four outputs are zero.
- R11: The R10 override also holds in the entry cycle itself, before emu_active rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_pin_negated | input | 1 | Core reset pin is in its negated state |
| reset_exc_start | input | 1 | Reset exception processing starts (strobe) |
| force_emu | input | 1 | Force-emulation control bit |
| trace_en | input | 1 | Trace-enable control bit |
| remap_en | input | 1 | Memory-remap control bit |
| dbg_irq_req | input | 1 | Debug interrupt request |
| dbg_enable | input | 1 | Debug interrupt enable |
| irq_exc_begin | input | 1 | Interrupt exception processing begins (strobe) |
| trace_exc_begin | input | 1 | Trace exception processing begins (strobe) |
| rte_retire | input | 1 | Return-from-exception retires (strobe) |
| irq_level_in | input | 3 | Incoming interrupt priority level |
| core_status | input | 4 | Normal status code from the core |
| acc_is_instr | input | 1 | Current access is an instruction fetch |
| emu_active | output | 1 | Emulation mode flag |
| pst_code | output | 4 | Processor status code |
| irq_level_out | output | 3 | Masked interrupt priority level |
| local_mem_off | output | 1 | Forces the cache and SRAM enables off |
| acc_ovr | output | 1 | Transfer type/modifier override is active |
| acc_tt | output | 2 | Override transfer type |
| acc_tm | output | 3 | Override transfer modifier |

## Verification
The two functions that can fall in the same cycle are mode entry and mode exit. An entry trigger can coincide with a retiring return-from-exception. The bench provokes this by sweeping all 1024 combinations of the ten control and strobe inputs, starting once from the idle state and once from inside emulation mode. For each combination it computes in the bench the expected status code, interrupt mask, override bundle and next flag. It compares the combinational outputs before the edge and the flag after it, so the entry-over-exit rule and the entry-cycle remap are both checked explicitly.

// File: rtl/emu_pkg.sv
// Package: emu_pkg
// Shared widths and code values for the emulation mode controller.
// Assumes a single clock domain. All values are fixed by the core's encoding.
package emu_pkg;
    localparam int PST_W   = 4;
    localparam int IPL_W   = 3;
    localparam int TT_W    = 2;
    localparam int TM_W    = 3;
    localparam int N_TRIG  = 3;

    localparam logic [PST_W-1:0] PST_ENTER   = 4'hD;
    localparam logic [PST_W-1:0] PST_LEAVE   = 4'h7;
    localparam logic [TT_W-1:0]  TT_EMU      = 2'h2;
    localparam logic [TM_W-1:0]  TM_EMU_DATA = 3'h5;
    localparam logic [TM_W-1:0]  TM_EMU_INSN = 3'h6;
endpackage

// File: rtl/emu_entry_detect.sv
// Module: emu_entry_detect
// ORs a set of qualified exception-boundary strobes into one entry event.
// Assumes each strobe lasts exactly one cycle and each qualifier is stable in that cycle.
module emu_entry_detect #(
    parameter int N = 3
) (
    input  logic [N-1:0] strobe,
    input  logic [N-1:0] qual,
    output logic         entry
);
    logic [N-1:0] hit;

    // One qualified hit per trigger source.
    for (genvar g = 0; g < N; g++) begin : g_trig
        assign hit[g] = strobe[g] & qual[g];
    end

    // Any hit is an entry event.
    always_comb entry = |hit;
endmodule

// File: rtl/emu_state.sv
// Module: emu_state
// Holds the emulation flag and derives the exit event. Entry has priority over exit.
// Assumes a synchronous active-low reset and one-cycle strobes.
module emu_state (
    input  logic clk,
    input  logic rst_n,
    input  logic entry,
    input  logic rte_retire,
    output logic emu_q,
    output logic exit_evt
);
    // An exit is a retire inside the mode that is not overridden by an entry.
    always_comb exit_evt = rte_retire & emu_q & ~entry;

    // Flag register: set on entry, cleared on exit or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        emu_q <= 1'b0;
        else if (entry)    emu_q <= 1'b1;
        else if (exit_evt) emu_q <= 1'b0;
    end

    assert_reset_clears_R1: assert property (@(posedge clk) !rst_n |=> !emu_q);
    assert_entry_sets_R8:   assert property (@(posedge clk) disable iff (!rst_n)
                                entry |=> emu_q);
    assert_retire_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
                                (emu_q && rte_retire && !entry) |=> !emu_q);
    assert_idle_retire_R5:  assert property (@(posedge clk) disable iff (!rst_n)
                                (!emu_q && !entry) |=> !emu_q);
endmodule

// File: rtl/emu_side_effects.sv
// Module: emu_side_effects
// Drives the interrupt mask and the remapped transfer attributes for emulation mode.
// Assumes emu_q is the registered flag and entry is the same-cycle entry event.
module emu_side_effects
    import emu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emu_q,
    input  logic             entry,
    input  logic             remap_en,
    input  logic             acc_is_instr,
    input  logic [IPL_W-1:0] irq_level_in,
    output logic [IPL_W-1:0] irq_level_out,
    output logic             local_mem_off,
    output logic             acc_ovr,
    output logic [TT_W-1:0]  acc_tt,
    output logic [TM_W-1:0]  acc_tm
);
    logic remap_live;

    // Remap covers the entry cycle, so the exception's own accesses are tagged.
    always_comb remap_live = remap_en & (emu_q | entry);

    // Mask all interrupt levels while in the mode.
    always_comb irq_level_out = emu_q ? '0 : irq_level_in;

    // Transfer attribute override and local memory disable.
    always_comb begin
        local_mem_off = remap_live;
        acc_ovr       = remap_live;
        acc_tt        = remap_live ? TT_EMU : '0;
        acc_tm        = '0;
        if (remap_live) acc_tm = acc_is_instr ? TM_EMU_INSN : TM_EMU_DATA;
    end

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
                              emu_q |-> (irq_level_out == '0));
    assert_ovr_type_R10:  assert property (@(posedge clk) disable iff (!rst_n)
                              acc_ovr |-> (acc_tt == TT_EMU && local_mem_off));
    assert_ovr_mod_R10:   assert property (@(posedge clk) disable iff (!rst_n)
                              acc_ovr |-> (acc_tm == (acc_is_instr ? TM_EMU_INSN : TM_EMU_DATA)));
endmodule

// File: rtl/emu_mode_ctrl.sv
// Module: emu_mode_ctrl
// Top of the debug emulation mode controller: entry detection, mode flag,
// status code selection and the mode's side effects.
// Assumes strobes from the core are one cycle wide and synchronous to clk.
module emu_mode_ctrl
    import emu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_pin_negated,
    input  logic             reset_exc_start,
    input  logic             force_emu,
    input  logic             trace_en,
    input  logic             remap_en,
    input  logic             dbg_irq_req,
    input  logic             dbg_enable,
    input  logic             irq_exc_begin,
    input  logic             trace_exc_begin,
    input  logic             rte_retire,
    input  logic [IPL_W-1:0] irq_level_in,
    input  logic [PST_W-1:0] core_status,
    input  logic             acc_is_instr,
    output logic             emu_active,
    output logic [PST_W-1:0] pst_code,
    output logic [IPL_W-1:0] irq_level_out,
    output logic             local_mem_off,
    output logic             acc_ovr,
    output logic [TT_W-1:0]  acc_tt,
    output logic [TM_W-1:0]  acc_tm
);
    logic [N_TRIG-1:0] trig_strobe;
    logic [N_TRIG-1:0] trig_qual;
    logic              entry;
    logic              exit_evt;
    logic              emu_q;

    // Gather the three boundary strobes and their qualifiers.
    always_comb begin
        trig_strobe = {trace_exc_begin, irq_exc_begin, reset_exc_start};
        trig_qual   = {trace_en, dbg_irq_req & dbg_enable, rst_pin_negated & force_emu};
    end

    emu_entry_detect #(.N(N_TRIG)) u_entry (
        .strobe (trig_strobe),
        .qual   (trig_qual),
        .entry  (entry)
    );

    emu_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry      (entry),
        .rte_retire (rte_retire),
        .emu_q      (emu_q),
        .exit_evt   (exit_evt)
    );

    emu_side_effects u_fx (
        .clk           (clk),
        .rst_n         (rst_n),
        .emu_q         (emu_q),
        .entry         (entry),
        .remap_en      (remap_en),
        .acc_is_instr  (acc_is_instr),
        .irq_level_in  (irq_level_in),
        .irq_level_out (irq_level_out),
        .local_mem_off (local_mem_off),
        .acc_ovr       (acc_ovr),
        .acc_tt        (acc_tt),
        .acc_tm        (acc_tm)
    );

    // Status code: entry marker, exit marker, or the core's own code.
    always_comb begin
        if (entry)         pst_code = PST_ENTER;
        else if (exit_evt) pst_code = PST_LEAVE;
        else               pst_code = core_status;
    end

    always_comb emu_active = emu_q;

    assert_entry_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
                              (reset_exc_start && rst_pin_negated && force_emu) |-> (pst_code == PST_ENTER));
    assert_exit_code_R7:  assert property (@(posedge clk) disable iff (!rst_n)
                              (emu_active && rte_retire && pst_code != PST_ENTER) |=> !emu_active);
    assert_trace_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
                              (trace_exc_begin && trace_en) |=> emu_active);
    assert_dbg_entry_R3:  assert property (@(posedge clk) disable iff (!rst_n)
                              (irq_exc_begin && dbg_irq_req && dbg_enable) |=> emu_active);
    assert_entry_remap_R11: assert property (@(posedge clk) disable iff (!rst_n)
                              (remap_en && pst_code == PST_ENTER && entry) |-> acc_ovr);
endmodule

// File: tb/emu_mode_ctrl_test.sv
module emu_mode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_pin_negated = 0, reset_exc_start = 0, force_emu = 0, trace_en = 0;
    logic       remap_en = 0, dbg_irq_req = 0, dbg_enable = 0, irq_exc_begin = 0;
    logic       trace_exc_begin = 0, rte_retire = 0, acc_is_instr = 0;
    logic [2:0] irq_level_in = 0;
    logic [3:0] core_status = 0;
    logic       emu_active, local_mem_off, acc_ovr;
    logic [3:0] pst_code;
    logic [2:0] irq_level_out;
    logic [1:0] acc_tt;
    logic [2:0] acc_tm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;  // 125 MHz

    emu_mode_ctrl uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {rst_pin_negated, reset_exc_start, force_emu, trace_en, remap_en} = '0;
        {dbg_irq_req, dbg_enable, irq_exc_begin, trace_exc_begin, rte_retire} = '0;
    endtask

    // Apply reset, and optionally enter emulation through the trace trigger.
    task automatic prepare(input bit in_emu);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        if (in_emu) begin
            trace_en = 1; trace_exc_begin = 1;
            @(negedge clk);
            idle_inputs();
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        core_status = 4'h3;
        irq_level_in = 3'd7;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(emu_active == 0, "R1 flag", emu_active, 0);
        check(pst_code == 4'h3, "R1 status", pst_code, 3);
        check(irq_level_out == 3'd7, "R1 irq", irq_level_out, 7);
        check(acc_ovr == 0, "R1 ovr", acc_ovr, 0);

        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 1024; v++) begin
                bit ent, ext, nxt, rem;
                logic [3:0] e_pst;
                logic [2:0] e_irq, e_tm;
                logic [1:0] e_tt;
                string tag;
                prepare(s[0]);
                force_emu       = v[0];
                trace_en        = v[1];
                remap_en        = v[2];
                dbg_irq_req     = v[3];
                dbg_enable      = v[4];
                rst_pin_negated = v[5];
                reset_exc_start = v[6];
                irq_exc_begin   = v[7];
                trace_exc_begin = v[8];
                rte_retire      = v[9];
                core_status     = 4'((v * 7) % 16);
                irq_level_in    = 3'((v >> 2) % 8);
                acc_is_instr    = v[0] ^ v[9];
                ent = (v[6] & v[5] & v[0]) | (v[7] & v[3] & v[4]) | (v[8] & v[1]);
                ext = v[9] & s[0] & ~ent;
                nxt = ent | (s[0] & ~v[9]);
                e_pst = ent ? 4'hD : (ext ? 4'h7 : core_status);
                e_irq = s[0] ? 3'd0 : irq_level_in;
                rem = v[2] & (s[0] | ent);
                e_tt = rem ? 2'h2 : 2'h0;
                e_tm = rem ? (acc_is_instr ? 3'h6 : 3'h5) : 3'h0;
                #1;
                tag = ent ? (v[9] ? "R8 status" : "R6 status") : "R7 status";
                check(pst_code == e_pst, tag, pst_code, e_pst);
                check(irq_level_out == e_irq, "R9 irq mask", irq_level_out, e_irq);
                tag = (rem && !s[0]) ? "R11 override" : "R10 override";
                check({local_mem_off, acc_ovr, acc_tt, acc_tm} == {rem, rem, e_tt, e_tm}, tag,
                      {local_mem_off, acc_ovr, acc_tt, acc_tm}, {rem, rem, e_tt, e_tm});
                @(negedge clk);
                idle_inputs();
                if (ent && v[9])  tag = "R8 flag";
                else if (v[6])    tag = "R2 flag";
                else if (v[7])    tag = "R3 flag";
                else if (v[8])    tag = "R4 flag";
                else              tag = "R5 flag";
                check(emu_active == nxt, tag, emu_active, nxt);
            end
        end

        // R1: reset while inside the mode
        prepare(1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(emu_active == 0, "R1 reset in mode", emu_active, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule